// File: doc/BRIEF.md
# ATM Cell Header Check and Delineation Tracker

This block checks each received 5-byte ATM cell header against its header check byte. It computes a syndrome, classifies the header as clean, single-bit errored or multi-bit errored, and repairs single-bit errors when it is allowed to. It also follows cell delineation at cell granularity through three states: HUNT, PRESYNC and SYNC. While in SYNC it runs in one of two modes. Correction mode repairs a single-bit error. Detection mode drops every errored cell.

A framer upstream presents one header per `hdr_valid_i` strobe. This block finds no bit-level cell boundaries and does not touch the payload. One cycle after each strobe it returns a pass/drop verdict and the header, repaired where that applies. It raises a one-cycle pulse for every repair so that an external 16-bit counter can count correctable errors. Three run-time thresholds are accepted as inputs: the error run that loses sync (ALPHA), the clean run that confirms sync (DELTA), and the clean run that restores correction mode (N).

Top module: `atm_hec_delin`

## Requirements
- R1: The expected check byte is CRC-8 with generator x^8+x^2+x+1 and zero initial value, fed MSB first over `hdr_i[39:8]` (`hdr_i[39]` first), then XORed with 0x55. It is carried in `hdr_i[7:0]`. A match means a clean header.
- R2: After reset, `state_o` is HUNT (2'd0), `det_mode_o` is 0, and `out_valid_o`, `pass_o` and `corr_o` are 0.
- R3: Each `hdr_valid_i` cycle produces exactly one `out_valid_o` cycle on the next clock, together with `pass_o`, `hdr_o` and `corr_o`. In that same cycle `state_o`/`det_mode_o` already show the updated state. `out_valid_o` is 0 in every other cycle. `hdr_o` is the repaired header when `corr_o` is 1 and the received header otherwise.
- R4: In HUNT, a clean header moves to PRESYNC (2'd1) and an errored header keeps HUNT. Every cell seen outside SYNC is dropped.
- R5: In PRESYNC, an errored header returns to HUNT. The DELTA-th consecutive clean header seen in PRESYNC enters SYNC (2'd2) in correction mode (`det_mode_o`=0).
- R6: In SYNC correction mode, a clean header is passed and the mode stays.
- R7: In SYNC correction mode with `corr_en_i`=1, a single-bit error is repaired and passed with a one-cycle `corr_o` pulse, and the block moves to detection mode (`det_mode_o`=1).
- R8: In SYNC correction mode, a multi-bit error drops the cell and moves the block to detection mode.
- R9: In detection mode, errored cells are dropped and clean cells are passed. The N-th consecutive clean cell returns the block to correction mode, and an errored cell restarts that run.
- R10: In SYNC, ALPHA consecutive errored headers in either mode, repaired ones included, move the block to HUNT. The cell that completes the run is dropped without a `corr_o` pulse. Any clean header clears the run.
- R11: With `corr_en_i`=0, a single-bit error is handled exactly like a multi-bit error, and `corr_o` stays 0.
- R12: A threshold input of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | Header present this cycle |
| hdr_i | input | 40 | Received header, first byte in [39:32], check byte in [7:0] |
| corr_en_i | input | 1 | Allow single-bit repair |
| alpha_i | input | CNT_W | Errored-header run that drops sync |
| delta_i | input | CNT_W | Clean-header run that confirms sync |
| n_i | input | CNT_W | Clean-header run that restores correction mode |
| out_valid_o | output | 1 | Verdict for the previous cycle's header |
| pass_o | output | 1 | 1 = forward cell, 0 = drop |
| hdr_o | output | 40 | Header, repaired when `corr_o` is 1 |
| corr_o | output | 1 | Pulse per repaired header |
| state_o | output | 2 | 0 HUNT, 1 PRESYNC, 2 SYNC |
| det_mode_o | output | 1 | 1 = detection mode inside SYNC |

## Verification
The bench targets repair of single-bit errors at every header position, both in the check byte and in the data bytes. A wrong syndrome table would either pass a header with the wrong bit flipped or drop a repairable cell. It targets the run counters at their exact boundaries: DELTA, N and ALPHA, including a value of 0. A counter that is off by one would enter SYNC, return to correction mode or lose sync one cell early or late. It also targets the ALPHA=1 case with a single-bit error in correction mode and correction disabled mid-run. A design that gave repair priority over loss of sync, or ignored the enable, would raise `corr_o` and pass a cell that must be dropped.

// File: rtl/atm_hec_pkg.sv
package atm_hec_pkg;

  localparam int HDR_W = 40;
  localparam int HEC_W = 8;
  localparam int DAT_W = HDR_W - HEC_W;
  localparam logic [HEC_W-1:0] HEC_COSET = 8'h55;
  localparam logic [HEC_W-1:0] HEC_POLY  = 8'h07;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_PRESYNC = 2'd1,
    ST_SYNC    = 2'd2
  } dl_state_e;

  // MSB-first CRC over the header data bytes, zero init, no coset
  function automatic logic [HEC_W-1:0] crc_data(input logic [DAT_W-1:0] d);
    logic [HEC_W-1:0] c;
    logic             fb;
    c = '0;
    for (int k = DAT_W - 1; k >= 0; k--) begin
      fb = c[HEC_W-1] ^ d[k];
      c  = {c[HEC_W-2:0], 1'b0};
      if (fb) c = c ^ HEC_POLY;
    end
    return c;
  endfunction

  // Syndrome produced by a lone flipped bit at header position pos
  function automatic logic [HEC_W-1:0] bit_syndrome(input int pos);
    logic [DAT_W-1:0] e;
    if (pos < HEC_W) return HEC_W'(1) << pos;
    e = DAT_W'(1) << (pos - HEC_W);
    return crc_data(e);
  endfunction

endpackage

// File: rtl/hec_syndrome.sv
module hec_syndrome
  import atm_hec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [HDR_W-1:0] hdr_i,
  output logic             clean_o,
  output logic             single_o,
  output logic [HDR_W-1:0] flip_o
);

  logic [HEC_W-1:0] syn;
  logic [HDR_W-1:0] hit;

  assign syn = crc_data(hdr_i[HDR_W-1:HEC_W]) ^ HEC_COSET ^ hdr_i[HEC_W-1:0];

  for (genvar gi = 0; gi < HDR_W; gi++) begin : g_loc
    localparam logic [HEC_W-1:0] SIG = bit_syndrome(gi);
    assign hit[gi] = (syn == SIG);
  end

  assign clean_o  = (syn == '0);
  assign single_o = |hit;
  assign flip_o   = hit;

  AST_SYN_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit)) else $error("syndrome table ambiguous"); // R1

endmodule

// File: rtl/hec_delin_fsm.sv
module hec_delin_fsm
  import atm_hec_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             clean_i,
  input  logic             single_i,
  input  logic             corr_en_i,
  input  logic [CNT_W-1:0] alpha_i,
  input  logic [CNT_W-1:0] delta_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic [HDR_W-1:0] hdr_raw_i,
  input  logic [HDR_W-1:0] hdr_fix_i,
  output logic             out_valid_o,
  output logic             pass_o,
  output logic             corr_o,
  output logic [HDR_W-1:0] hdr_o,
  output logic [1:0]       state_o,
  output logic             det_mode_o
);

  localparam int CW1 = CNT_W + 1;

  dl_state_e        state_q, state_d;
  logic             det_q, det_d;
  logic [CNT_W-1:0] pre_q, pre_d, err_q, err_d, cln_q, cln_d;
  logic             pass_d, fix_d;
  logic [CW1-1:0]   alpha_eff, delta_eff, n_eff;

  // zero thresholds behave as one
  assign alpha_eff = (alpha_i == '0) ? CW1'(1) : {1'b0, alpha_i};
  assign delta_eff = (delta_i == '0) ? CW1'(1) : {1'b0, delta_i};
  assign n_eff     = (n_i     == '0) ? CW1'(1) : {1'b0, n_i};

  always_comb begin
    state_d = state_q;
    det_d   = det_q;
    pre_d   = pre_q;
    err_d   = err_q;
    cln_d   = cln_q;
    pass_d  = 1'b0;
    fix_d   = 1'b0;
    if (valid_i) begin
      unique case (state_q)
        ST_HUNT: begin
          if (clean_i) begin
            state_d = ST_PRESYNC;
            pre_d   = '0;
          end
        end
        ST_PRESYNC: begin
          if (!clean_i) begin
            state_d = ST_HUNT;
          end else if ({1'b0, pre_q} + CW1'(1) >= delta_eff) begin
            state_d = ST_SYNC;
            det_d   = 1'b0;
            err_d   = '0;
            cln_d   = '0;
          end else begin
            pre_d = pre_q + CNT_W'(1);
          end
        end
        ST_SYNC: begin
          if (clean_i) begin
            pass_d = 1'b1;
            err_d  = '0;
            if (det_q) begin
              if ({1'b0, cln_q} + CW1'(1) >= n_eff) begin
                det_d = 1'b0;
                cln_d = '0;
              end else begin
                cln_d = cln_q + CNT_W'(1);
              end
            end
          end else begin
            cln_d = '0;
            if ({1'b0, err_q} + CW1'(1) >= alpha_eff) begin
              state_d = ST_HUNT;
              det_d   = 1'b0;
              err_d   = '0;
            end else begin
              err_d = err_q + CNT_W'(1);
              if (!det_q && single_i && corr_en_i) begin
                pass_d = 1'b1;
                fix_d  = 1'b1;
              end
              det_d = 1'b1;
            end
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_HUNT;
      det_q       <= 1'b0;
      pre_q       <= '0;
      err_q       <= '0;
      cln_q       <= '0;
      out_valid_o <= 1'b0;
      pass_o      <= 1'b0;
      corr_o      <= 1'b0;
      hdr_o       <= '0;
    end else begin
      state_q     <= state_d;
      det_q       <= det_d;
      pre_q       <= pre_d;
      err_q       <= err_d;
      cln_q       <= cln_d;
      out_valid_o <= valid_i;
      pass_o      <= pass_d;
      corr_o      <= fix_d;
      if (valid_i) hdr_o <= fix_d ? hdr_fix_i : hdr_raw_i;
    end
  end

  assign state_o    = state_q;
  assign det_mode_o = det_q;

  AST_PASS_ONLY_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && pass_o) |-> ($past(state_q) == ST_SYNC)) else $error("pass outside sync"); // R4
  AST_PRESYNC_ERR_HUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && state_q == ST_PRESYNC && !clean_i) |=> (state_q == ST_HUNT)) else $error("presync error kept"); // R5
  AST_CORR_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o |-> (pass_o && out_valid_o && det_q)) else $error("corr pulse without pass"); // R7
  AST_DET_EXIT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(det_q) && state_q == ST_SYNC) |-> $past(valid_i && clean_i)) else $error("left detection on error"); // R9
  AST_NO_CORR_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !corr_en_i) |=> !corr_o) else $error("repair while disabled"); // R11
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !out_valid_o) else $error("spurious verdict"); // R3

endmodule

// File: rtl/atm_hec_delin.sv
module atm_hec_delin
  import atm_hec_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hdr_valid_i,
  input  logic [39:0]      hdr_i,
  input  logic             corr_en_i,
  input  logic [CNT_W-1:0] alpha_i,
  input  logic [CNT_W-1:0] delta_i,
  input  logic [CNT_W-1:0] n_i,
  output logic             out_valid_o,
  output logic             pass_o,
  output logic [39:0]      hdr_o,
  output logic             corr_o,
  output logic [1:0]       state_o,
  output logic             det_mode_o
);

  logic             clean, single;
  logic [HDR_W-1:0] flip;

  hec_syndrome u_syn (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hdr_i    (hdr_i),
    .clean_o  (clean),
    .single_o (single),
    .flip_o   (flip)
  );

  hec_delin_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (hdr_valid_i),
    .clean_i     (clean),
    .single_i    (single),
    .corr_en_i   (corr_en_i),
    .alpha_i     (alpha_i),
    .delta_i     (delta_i),
    .n_i         (n_i),
    .hdr_raw_i   (hdr_i),
    .hdr_fix_i   (hdr_i ^ flip),
    .out_valid_o (out_valid_o),
    .pass_o      (pass_o),
    .corr_o      (corr_o),
    .hdr_o       (hdr_o),
    .state_o     (state_o),
    .det_mode_o  (det_mode_o)
  );

  AST_CLEAN_NOT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i |-> !(clean && single)) else $error("clean header flagged repairable"); // R1

endmodule

// File: tb/atm_hec_delin_tb.sv
module atm_hec_delin_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             hdr_valid_i = 1'b0;
  logic [39:0]      hdr_i = '0;
  logic             corr_en_i = 1'b1;
  logic [CNT_W-1:0] alpha_i = 4'd3, delta_i = 4'd2, n_i = 4'd2;
  logic             out_valid_o, pass_o, corr_o, det_mode_o;
  logic [39:0]      hdr_o;
  logic [1:0]       state_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  int m_state = 0, m_p = 0, m_e = 0, m_c = 0;
  bit m_det = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atm_hec_delin #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .hdr_valid_i(hdr_valid_i), .hdr_i(hdr_i),
    .corr_en_i(corr_en_i), .alpha_i(alpha_i), .delta_i(delta_i), .n_i(n_i),
    .out_valid_o(out_valid_o), .pass_o(pass_o), .hdr_o(hdr_o), .corr_o(corr_o),
    .state_o(state_o), .det_mode_o(det_mode_o)
  );

  function automatic logic [7:0] tb_hec(input logic [31:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      logic fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c ^ 8'h55;
  endfunction

  function automatic int eff(input logic [CNT_W-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // kind: 0 clean, 1 single-bit, 2 double-bit
  task automatic model(input int kind, output bit ep, output bit ec);
    ep = 0; ec = 0;
    case (m_state)
      0: if (kind == 0) begin m_state = 1; m_p = 0; end
      1: begin
        if (kind != 0) m_state = 0;
        else if (m_p + 1 >= eff(delta_i)) begin m_state = 2; m_det = 0; m_e = 0; m_c = 0; end
        else m_p++;
      end
      default: begin
        if (kind == 0) begin
          ep = 1; m_e = 0;
          if (m_det) begin
            if (m_c + 1 >= eff(n_i)) begin m_det = 0; m_c = 0; end else m_c++;
          end
        end else begin
          m_c = 0;
          if (m_e + 1 >= eff(alpha_i)) begin m_state = 0; m_det = 0; m_e = 0; end
          else begin
            m_e++;
            if (!m_det && kind == 1 && corr_en_i) begin ep = 1; ec = 1; end
            m_det = 1;
          end
        end
      end
    endcase
  endtask

  task automatic send(input int kind, input int pos, input string tag);
    logic [31:0] d = $urandom;
    logic [39:0] good = {d, tb_hec(d)};
    logic [39:0] bad = good;
    int p2;
    bit ep, ec;
    if (kind >= 1) bad[pos] = ~bad[pos];
    if (kind == 2) begin
      p2 = (pos + 1 + int'($urandom_range(0, 38))) % 40;
      bad[p2] = ~bad[p2];
    end
    model(kind, ep, ec);
    @(negedge clk);
    hdr_valid_i = 1'b1;
    hdr_i = bad;
    @(negedge clk);
    hdr_valid_i = 1'b0;
    chk(tag, "out_valid", out_valid_o, 1);
    chk(tag, "pass", pass_o, ep);
    chk(tag, "corr", corr_o, ec);
    chk(tag, "hdr", hdr_o, ec ? good : bad);
    chk(tag, "state", state_o, m_state);
    chk(tag, "det_mode", det_mode_o, m_det);
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    chk(tag, "out_valid idle", out_valid_o, 0);
    chk(tag, "corr idle", corr_o, 0);
  endtask

  task automatic to_sync(input string tag);
    while (m_state != 2) send(0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    chk("R2", "state", state_o, 0);
    chk("R2", "det_mode", det_mode_o, 0);
    chk("R2", "out_valid", out_valid_o, 0);
    chk("R2", "pass", pass_o, 0);
    chk("R2", "corr", corr_o, 0);
    rst_ni = 1'b1;

    // delineation entry, alpha=3 delta=2 n=2
    send(2, 5, "R4");            // stays HUNT
    send(1, 3, "R4");
    send(0, 0, "R4");            // -> PRESYNC
    send(1, 20, "R5");           // -> HUNT
    send(0, 0, "R4");
    send(0, 0, "R5");
    send(0, 0, "R5");            // -> SYNC
    idle_check("R3");
    send(0, 0, "R6");
    send(0, 0, "R6");
    // single-bit repair at every position
    for (int p = 0; p < 40; p++) begin
      send(1, p, "R7");          // repaired, -> detection
      send(0, 0, "R9");
      send(0, 0, "R9");          // back to correction
    end
    idle_check("R3");
    send(2, 7, "R8");            // drop, -> detection
    send(0, 0, "R9");
    send(1, 30, "R9");           // dropped in detection, restarts run
    send(0, 0, "R9");
    send(0, 0, "R9");
    // lose sync
    send(1, 1, "R10");
    send(2, 9, "R10");
    send(0, 0, "R10");           // clears run
    send(2, 11, "R10");
    send(1, 12, "R10");
    send(2, 13, "R10");          // -> HUNT
    to_sync("R10");
    // alpha=1: repair loses to sync loss
    alpha_i = 4'd1;
    send(1, 15, "R10");
    to_sync("R10");
    alpha_i = 4'd3;
    corr_en_i = 1'b0;
    send(1, 22, "R11");
    send(0, 0, "R11");
    send(0, 0, "R11");
    send(1, 2, "R11");
    corr_en_i = 1'b1;
    // zero thresholds
    alpha_i = 4'd0; delta_i = 4'd0; n_i = 4'd0;
    send(2, 4, "R12");
    send(0, 0, "R12");
    send(0, 0, "R12");
    send(0, 0, "R12");
    send(1, 6, "R12");
    alpha_i = 4'd2;
    send(1, 6, "R12");
    send(0, 0, "R12");
    send(2, 8, "R12");

    // constrained random
    for (int blk = 0; blk < 8; blk++) begin
      alpha_i = CNT_W'($urandom_range(0, 7));
      delta_i = CNT_W'($urandom_range(0, 8));
      n_i = CNT_W'($urandom_range(0, 6));
      corr_en_i = (blk % 3) != 2;
      for (int k = 0; k < 300; k++) begin
        int r = int'($urandom_range(0, 99));
        int kind = (r < 70) ? 0 : (r < 85) ? 1 : 2;
        send(kind, int'($urandom_range(0, 39)), "R1");
        if ($urandom_range(0, 7) == 0) idle_check("R3");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule